// File: doc/BRIEF.md
# Quad-Pumped Data Bus Receiver with Per-Lane Inversion

This block receives a wide, active-low data bus that carries four transfers in each bus clock period. The bus is cut into lanes of 16 bits. Each lane has its own pair of source-synchronous strobes and its own active-low inversion flag. On every falling strobe edge the receiver latches the lane, takes the inversion into account, and writes the beat into a small per-lane buffer in the strobe domain.

Gray-coded write pointers cross into the bus clock domain through two-flop synchronizers. When every lane has delivered all four beats of one transfer, the block puts out the whole 256-bit line with a one-cycle valid pulse. A transfer counts only if the active-low ready input is asserted at the strobe edges. Beats that arrive without ready are dropped.

Top module: `qp_rx_line`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `line_vld` is 0 and `line_q` is all zeros after that edge.
- R2: Lane l covers pins `dq_n[16l+15:16l]`. It is captured only by `stb_even_n[l]` and `stb_odd_n[l]`, and only `flip_n[l]` can change how it is read.
- R3: Within one bus clock, beat 0 is the first falling edge of the even strobe, beat 1 the first falling edge of the odd strobe, beat 2 the second even edge and beat 3 the second odd edge. Beat b appears at `line_q[64b+63:64b]`, and lane l within it at bits `[16l+15:16l]` of that word.
- R4: When `flip_n[l]` is high at the capturing edge, the stored lane value is the bitwise complement of the pins, because the bus is active low.
- R5: When `flip_n[l]` is low at the capturing edge, the stored lane value equals the pins. The flag is sampled per beat and per lane.
- R6: Beats whose strobe edge sees `rdy_n` high are discarded. They produce no line and do not shift the beat positions of later transfers.
- R7: For a transfer whose four beats follow rising `clk` edge E, `line_vld` is 1 for exactly the cycle after edge E+3.
- R8: Transfers in consecutive bus clocks each produce their own line, in order, in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, also seen by the strobe domains |
| dq_n | input | 64 | Active-low data pins, four lanes of 16 |
| stb_even_n | input | 4 | Per-lane strobe whose falling edges carry beats 0 and 2 |
| stb_odd_n | input | 4 | Per-lane strobe whose falling edges carry beats 1 and 3 |
| flip_n | input | 4 | Per-lane active-low inversion flag, sampled with its data |
| rdy_n | input | 1 | Active-low data-ready; beats without it are dropped |
| line_vld | output | 1 | One-cycle pulse marking a new line |
| line_q | output | 256 | Assembled line, beat b in word b |

## Verification
If a lane's beat slot goes wrong, for example after beats are dropped, its 16-bit fields land in swapped beat words of the very next line. A wrong write or read pointer either withholds `line_vld` or raises it with stale data. The scoreboard sees that three clocks after the transfer. An inversion error flips a single 16-bit field in the same line, so each lane and beat is checked on its own.

// File: rtl/qp_rx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the quad-pumped receiver.
// Assumes: two beats per strobe per bus clock, four beats per line.
package qp_rx_pkg;
    // Which of the two beats a strobe edge is carrying.
    typedef enum logic {
        SLOT_FIRST  = 1'b0,
        SLOT_SECOND = 1'b1
    } slot_e;

    localparam int BEATS_PER_LINE  = 4;
    localparam int BEATS_PER_STROBE = 2;
endpackage

// File: rtl/qp_strobe_capture.sv
`timescale 1ns/1ps
// Captures one lane on the falling edges of one strobe: two beats per
// transfer, written into a DEPTH-entry buffer indexed by a pointer that
// advances once per completed transfer and is published in Gray code.
// Assumes: rdy_n is held for a whole bus clock; DEPTH is a power of two;
// the strobe keeps toggling while rst_n is low.
module qp_strobe_capture
    import qp_rx_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      strobe_n,
    input  logic                      rst_n,
    input  logic [LANE_W-1:0]         pin_d,
    input  logic                      flip_n,
    input  logic                      rdy_n,
    output logic [DEPTH*LANE_W-1:0]   first_mem_o,
    output logic [DEPTH*LANE_W-1:0]   second_mem_o,
    output logic [PTR_W-1:0]          wr_gray_o
);

    logic [LANE_W-1:0] beat_val;
    logic [LANE_W-1:0] first_mem  [DEPTH];
    logic [LANE_W-1:0] second_mem [DEPTH];
    logic [PTR_W-1:0]  wr_bin;
    logic [PTR_W-1:0]  wr_bin_nx;
    logic [PTR_W-1:0]  wr_gray;
    slot_e             slot;

    // Undo the active-low sense unless this beat was sent inverted.
    always_comb begin
        beat_val  = flip_n ? ~pin_d : pin_d;
        wr_bin_nx = wr_bin + 1'b1;
    end

    // Track beat slot and transfer pointer; drop beats without ready.
    always_ff @(negedge strobe_n) begin
        if (!rst_n) begin
            slot    <= SLOT_FIRST;
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (!rdy_n) begin
            if (slot == SLOT_FIRST) begin
                slot <= SLOT_SECOND;
            end else begin
                slot    <= SLOT_FIRST;
                wr_bin  <= wr_bin_nx;
                wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
            end
        end else begin
            slot <= SLOT_FIRST;
        end
    end

    // Store the beat in the buffer entry of the current transfer.
    always_ff @(negedge strobe_n) begin
        if (rst_n && !rdy_n) begin
            if (slot == SLOT_FIRST) begin
                first_mem[wr_bin] <= beat_val;
            end else begin
                second_mem[wr_bin] <= beat_val;
            end
        end
    end

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_flat
            assign first_mem_o[e*LANE_W +: LANE_W]  = first_mem[e];
            assign second_mem_o[e*LANE_W +: LANE_W] = second_mem[e];
        end
    endgenerate

    assign wr_gray_o = wr_gray;

    // R8: the published pointer moves by at most one Gray step per edge.
    p_gray_step_r8: assert property (@(negedge strobe_n) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R6: an edge without ready never advances the transfer pointer.
    p_idle_hold_r6: assert property (@(negedge strobe_n) disable iff (!rst_n)
        rdy_n |=> $stable(wr_gray));

endmodule

// File: rtl/qp_gray_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer entering the bus clock.
// Assumes: the source changes at most one bit between destination edges.
module qp_gray_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two register stages to settle the crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/qp_line_build.sv
`timescale 1ns/1ps
// Bus clock side: waits until every lane's even and odd pointers have moved
// past the read pointer, then reads one entry from all buffers and outputs
// the 4-beat line with a one-cycle valid.
// Assumes: buffer entries are stable while the synchronized pointers show them.
module qp_line_build
    import qp_rx_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BEAT_W = LANES * LANE_W,
    localparam int MEM_W  = LANES * DEPTH * LANE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES*PTR_W-1:0]       even_gray_s,
    input  logic [LANES*PTR_W-1:0]       odd_gray_s,
    input  logic [MEM_W-1:0]             even_first,
    input  logic [MEM_W-1:0]             even_second,
    input  logic [MEM_W-1:0]             odd_first,
    input  logic [MEM_W-1:0]             odd_second,
    output logic                         line_vld,
    output logic [BEATS_PER_LINE*BEAT_W-1:0] line_q
);

    logic [PTR_W-1:0] rd_bin;
    logic [PTR_W-1:0] rd_bin_nx;
    logic [PTR_W-1:0] rd_gray;
    logic             avail;
    logic [BEATS_PER_LINE*BEAT_W-1:0] next_line;

    // A line is ready once every pointer of every lane differs from read.
    always_comb begin
        avail = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (even_gray_s[l*PTR_W +: PTR_W] == rd_gray) avail = 1'b0;
            if (odd_gray_s[l*PTR_W +: PTR_W]  == rd_gray) avail = 1'b0;
        end
        rd_bin_nx = rd_bin + 1'b1;
    end

    // Gather the entry at the read pointer into beat order 0..3.
    always_comb begin
        next_line = '0;
        for (int l = 0; l < LANES; l++) begin
            next_line[0*BEAT_W + l*LANE_W +: LANE_W] =
                even_first[(l*DEPTH + int'(rd_bin))*LANE_W +: LANE_W];
            next_line[1*BEAT_W + l*LANE_W +: LANE_W] =
                odd_first[(l*DEPTH + int'(rd_bin))*LANE_W +: LANE_W];
            next_line[2*BEAT_W + l*LANE_W +: LANE_W] =
                even_second[(l*DEPTH + int'(rd_bin))*LANE_W +: LANE_W];
            next_line[3*BEAT_W + l*LANE_W +: LANE_W] =
                odd_second[(l*DEPTH + int'(rd_bin))*LANE_W +: LANE_W];
        end
    end

    // Register the line, pulse valid and advance the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bin   <= '0;
            rd_gray  <= '0;
            line_vld <= 1'b0;
            line_q   <= '0;
        end else begin
            line_vld <= avail;
            if (avail) begin
                line_q  <= next_line;
                rd_bin  <= rd_bin_nx;
                rd_gray <= rd_bin_nx ^ (rd_bin_nx >> 1);
            end
        end
    end

    // R1: reset leaves the output quiet and cleared.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!line_vld && line_q == '0));

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_chk
            // R7: synchronized pointers never jump more than one Gray step.
            p_sync_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(even_gray_s[l*PTR_W +: PTR_W] ^
                           $past(even_gray_s[l*PTR_W +: PTR_W])) <= 1 &&
                $countones(odd_gray_s[l*PTR_W +: PTR_W] ^
                           $past(odd_gray_s[l*PTR_W +: PTR_W])) <= 1);
        end
    endgenerate

endmodule

// File: rtl/qp_rx_line.sv
`timescale 1ns/1ps
// Quad-pumped receiver top: per lane, one capture unit on each strobe
// and a synchronizer for each pointer, then the line builder.
// Assumes: lane count, lane width and buffer depth are set by parameters;
// four beats per line, two per strobe.
module qp_rx_line
    import qp_rx_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BUS_W  = LANES * LANE_W,
    localparam int MEM_W  = LANES * DEPTH * LANE_W,
    localparam int LINE_W = BEATS_PER_LINE * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  dq_n,
    input  logic [LANES-1:0]  stb_even_n,
    input  logic [LANES-1:0]  stb_odd_n,
    input  logic [LANES-1:0]  flip_n,
    input  logic              rdy_n,
    output logic              line_vld,
    output logic [LINE_W-1:0] line_q
);

    logic [MEM_W-1:0]       even_first;
    logic [MEM_W-1:0]       even_second;
    logic [MEM_W-1:0]       odd_first;
    logic [MEM_W-1:0]       odd_second;
    logic [LANES*PTR_W-1:0] even_gray;
    logic [LANES*PTR_W-1:0] odd_gray;
    logic [LANES*PTR_W-1:0] even_gray_s;
    logic [LANES*PTR_W-1:0] odd_gray_s;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            qp_strobe_capture #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_even (
                .strobe_n     (stb_even_n[l]),
                .rst_n        (rst_n),
                .pin_d        (dq_n[l*LANE_W +: LANE_W]),
                .flip_n       (flip_n[l]),
                .rdy_n        (rdy_n),
                .first_mem_o  (even_first[l*DEPTH*LANE_W +: DEPTH*LANE_W]),
                .second_mem_o (even_second[l*DEPTH*LANE_W +: DEPTH*LANE_W]),
                .wr_gray_o    (even_gray[l*PTR_W +: PTR_W])
            );

            qp_strobe_capture #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_odd (
                .strobe_n     (stb_odd_n[l]),
                .rst_n        (rst_n),
                .pin_d        (dq_n[l*LANE_W +: LANE_W]),
                .flip_n       (flip_n[l]),
                .rdy_n        (rdy_n),
                .first_mem_o  (odd_first[l*DEPTH*LANE_W +: DEPTH*LANE_W]),
                .second_mem_o (odd_second[l*DEPTH*LANE_W +: DEPTH*LANE_W]),
                .wr_gray_o    (odd_gray[l*PTR_W +: PTR_W])
            );

            qp_gray_sync #(.W(PTR_W)) u_sync_even (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (even_gray[l*PTR_W +: PTR_W]),
                .q     (even_gray_s[l*PTR_W +: PTR_W])
            );

            qp_gray_sync #(.W(PTR_W)) u_sync_odd (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (odd_gray[l*PTR_W +: PTR_W]),
                .q     (odd_gray_s[l*PTR_W +: PTR_W])
            );
        end
    endgenerate

    qp_line_build #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_build (
        .clk         (clk),
        .rst_n       (rst_n),
        .even_gray_s (even_gray_s),
        .odd_gray_s  (odd_gray_s),
        .even_first  (even_first),
        .even_second (even_second),
        .odd_first   (odd_first),
        .odd_second  (odd_second),
        .line_vld    (line_vld),
        .line_q      (line_q)
    );

endmodule

// File: tb/sim_qp_rx_line.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task pushes the expected line and start
// cycle; a monitor at the falling clk edge pops and compares.
module sim_qp_rx_line;
    localparam int LW = 16;
    localparam int NL = 4;
    localparam int BW = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [BW-1:0]  dq_n = '0;
    logic           stb_e = 1'b1;
    logic           stb_o = 1'b1;
    logic [NL-1:0]  flip_n = '1;
    logic           rdy_n = 1'b1;
    logic           line_vld;
    logic [4*BW-1:0] line_q;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [4*BW-1:0] exp_line[$];
    int              exp_cyc[$];
    string           exp_tag[$];

    qp_rx_line u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .dq_n       (dq_n),
        .stb_even_n ({NL{stb_e}}),
        .stb_odd_n  ({NL{stb_o}}),
        .flip_n     (flip_n),
        .rdy_n      (rdy_n),
        .line_vld   (line_vld),
        .line_q     (line_q)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Strobes derived from clk: even falls at 1.25/6.25, odd at 3.75/8.75.
    initial begin
        forever begin
            @(posedge clk);
            #1.25 stb_e = 1'b0; stb_o = 1'b1;
            #2.5  stb_e = 1'b1; stb_o = 1'b0;
            #2.5  stb_e = 1'b0; stb_o = 1'b1;
            #2.5  stb_e = 1'b1; stb_o = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [4*BW-1:0] act, input logic [4*BW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive one bus clock of four beats; queue the expected line if ready.
    task automatic send(input logic [3:0][BW-1:0] pins,
                        input logic [3:0][NL-1:0] flips,
                        input bit rdy, input string tag);
        logic [4*BW-1:0] expv;
        int e0;
        expv = '0;
        @(posedge clk);
        #0.2;
        e0 = cyc;
        rdy_n = ~rdy;
        for (int b = 0; b < 4; b++) begin
            dq_n   = pins[b];
            flip_n = flips[b];
            for (int l = 0; l < NL; l++) begin
                // flip_n low: sent inverted, read as-is; high: complement.
                expv[b*BW + l*LW +: LW] = flips[b][l] ? ~pins[b][l*LW +: LW]
                                                      :  pins[b][l*LW +: LW];
            end
            if (b < 3) #2.5;
        end
        if (rdy) begin
            exp_line.push_back(expv);
            exp_cyc.push_back(e0);
            exp_tag.push_back(tag);
        end
    endtask

    task automatic idle();
        @(posedge clk);
        #0.2;
        rdy_n = 1'b1;
    endtask

    // Monitor: compare each produced line against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_cyc.size() > 0 && !line_vld && cyc > exp_cyc[0] + 3) begin
                check(1'b0, "R7 line missing", line_q, exp_line[0]);
                void'(exp_line.pop_front());
                void'(exp_cyc.pop_front());
                void'(exp_tag.pop_front());
            end
            if (line_vld) begin
                if (exp_line.size() == 0) begin
                    check(1'b0, "R6 unexpected line", line_q, '0);
                end else begin
                    logic [4*BW-1:0] ev;
                    int ec;
                    string et;
                    ev = exp_line.pop_front();
                    ec = exp_cyc.pop_front();
                    et = exp_tag.pop_front();
                    check(line_q == ev, et, line_q, ev);
                    check(cyc == ec + 3, "R7 latency",
                          256'(cyc), 256'(ec + 3));
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog expired actual=%0d expected=<20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0][BW-1:0] p;
        logic [3:0][NL-1:0] f;

        repeat (4) @(negedge clk);
        // R1: reset state of the outputs.
        check(line_vld == 1'b0 && line_q == '0, "R1 reset state",
              line_q, '0);
        rst_n = 1'b1;
        repeat (2) idle();

        // R4 R3: no inversion, distinct beat values.
        p = {64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
             64'h5555_AAAA_3333_CCCC, 64'hDEAD_BEEF_F00D_CAFE};
        f = {4'hF, 4'hF, 4'hF, 4'hF};
        send(p, f, 1'b1, "R4 R3 plain line");

        // R5: every lane and beat sent inverted.
        f = {4'h0, 4'h0, 4'h0, 4'h0};
        send(p, f, 1'b1, "R5 all inverted");

        // R6: a transfer without ready is dropped.
        f = {4'h3, 4'h0, 4'hF, 4'h5};
        send({64'h1111_2222_3333_4444, 64'h5, 64'h6, 64'h7}, f, 1'b0, "R6");
        idle();

        // R5 R2: inversion differs per lane and per beat.
        f = {4'b0110, 4'b1001, 4'b0011, 4'b1010};
        send(p, f, 1'b1, "R5 R2 mixed inversion");

        // R2 R3: each lane and beat carries a tagged value.
        for (int b = 0; b < 4; b++)
            for (int l = 0; l < NL; l++)
                p[b][l*LW +: LW] = 16'hA000 + 16'(b*16 + l);
        f = {4'hF, 4'hF, 4'hF, 4'hF};
        send(p, f, 1'b1, "R2 R3 lane and beat map");
        repeat (3) idle();

        // R8: back-to-back transfers.
        for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < 4; b++)
                p[b] = {16'(k), 16'(b), 16'hC3C3 ^ 16'(k*4+b), 16'(~k)};
            f = {4'(k), 4'(~k), 4'(k+1), 4'(k^5)};
            send(p, f, 1'b1, "R8 back-to-back");
        end
        repeat (8) idle();

        @(negedge clk);
        check(exp_line.size() == 0, "R8 all lines delivered",
              256'(exp_line.size()), '0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule